// File: doc/BRIEF.md
# Upper Data Byte Staging Latch

This block lets a host with an 8-bit data path move complete 16-bit words across a 16-bit ISA slot. The lower byte travels directly; this block handles only the upper byte (ISA D15..D8) by staging it in two byte-wide registers.

The first register, called the outbound register, holds the upper byte for writes. The host loads it by writing to the outbound host address. Its contents are placed on the upper ISA lines during every window write, whatever width the target card uses.

The second register, called the inbound register, holds the upper byte from reads. It captures the upper ISA lines at the end of every window read. The host reads it back from the inbound host address. Software can ignore it after an 8-bit read.

Reading the outbound address clears the outbound register, so a stale upper byte does not leak into later writes.

The block is synchronous to one clock. Window strobes are active-high levels that span one or more cycles. The upper-byte lines are presented as a data value with an output enable, and the pad drives them only while the enable is high. The host and ISA sides are plain level-controlled ports. No transfer ever stalls, so there is no valid/ready handshake and no back-pressure to describe.

Top module: `hibyte_stage`

## Requirements
- R1: After reset, both the outbound and inbound registers hold 0x00.
- R2: A host write (host_wr=1) with host_sel_out=1 loads host_wdata into the outbound register, and the new value is visible from the next cycle.
- R3: While isa_win_wr=1, isa_hi_oe is 1 and isa_hi_out equals the outbound register's current value.
- R4: While isa_win_wr=0, isa_hi_oe is 0 and isa_hi_out is 0x00.
- R5: When isa_win_rd falls from 1 to 0, the inbound register takes the isa_hi_in value from the last cycle in which isa_win_rd was 1. The new value is readable from the cycle after the strobe was first seen low.
- R6: host_rdata shows the inbound register in the same cycle whenever host_rd=1 and host_sel_in=1. In every other cycle, host_rdata is 0x00.
- R7: A host write with host_sel_in=1 changes neither register.
- R8: A host read with host_sel_out=1 and host_wr=0 clears the outbound register to 0x00 from the next cycle. If host_wr=1 and host_rd=1 together with host_sel_out=1, the write wins.
- R9: The inbound register changes only at the end of a read strobe. In all other cycles it holds its value, including while a strobe is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_out | input | 1 | Host address decodes to the outbound register |
| host_sel_in | input | 1 | Host address decodes to the inbound register |
| host_wr | input | 1 | Host write cycle |
| host_rd | input | 1 | Host read cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| isa_win_wr | input | 1 | ISA window write strobe, active high |
| isa_win_rd | input | 1 | ISA window read strobe, active high |
| isa_hi_in | input | 8 | Sampled ISA D15..D8 |
| isa_hi_out | output | 8 | Value for ISA D15..D8 |
| isa_hi_oe | output | 1 | Drive enable for ISA D15..D8 |

## Verification
The bench targets reads whose strobe lasts several cycles while the bus value keeps changing. A latch that captured at the start of the strobe, or on every active cycle, would return the wrong byte or would change before the strobe ends.

It also issues a read of the outbound address followed directly by a window write. A design that ignored the clear would drive stale data onto the bus.

Writes to the inbound address and simultaneous read/write cycles on the outbound address check for unintended side effects and for the wrong priority. Random cycles then mix all of these against a reference model.

// File: rtl/hibyte_pkg.sv
package hibyte_pkg;
  localparam int unsigned HB_W = 8;
  typedef logic [HB_W-1:0] hb_byte_t;
  localparam hb_byte_t HB_RESET = '0;
endpackage

// File: rtl/hibyte_outbound.sv
module hibyte_outbound
  import hibyte_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  logic     clear_en,
  input  hb_byte_t load_val,
  output hb_byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= HB_RESET;
    else if (load_en)  q <= load_val;
    else if (clear_en) q <= HB_RESET;
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q == $past(load_val));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en && !load_en) |=> q == HB_RESET);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_en && !load_en) |=> $stable(q));
endmodule

// File: rtl/hibyte_inbound.sv
module hibyte_inbound
  import hibyte_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe,
  input  hb_byte_t bus_in,
  output hb_byte_t q
);
  logic     strobe_q;
  hb_byte_t bus_q;
  logic     ended;

  assign ended = strobe_q && !strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      bus_q    <= HB_RESET;
      q        <= HB_RESET;
    end else begin
      strobe_q <= strobe;
      bus_q    <= bus_in;
      if (ended) q <= bus_q;
    end
  end

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && !strobe && $past(rst_n)) |=> q == $past(bus_in, 2));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> $stable(q));
endmodule

// File: rtl/hibyte_stage.sv
module hibyte_stage
  import hibyte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel_out,
  input  logic       host_sel_in,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       isa_win_wr,
  input  logic       isa_win_rd,
  input  logic [7:0] isa_hi_in,
  output logic [7:0] isa_hi_out,
  output logic       isa_hi_oe
);
  hb_byte_t out_q, in_q;

  hibyte_outbound u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (host_wr && host_sel_out),
    .clear_en (host_rd && host_sel_out),
    .load_val (host_wdata),
    .q        (out_q)
  );

  hibyte_inbound u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (isa_win_rd),
    .bus_in (isa_hi_in),
    .q      (in_q)
  );

  assign isa_hi_oe  = isa_win_wr;
  assign isa_hi_out = isa_win_wr ? out_q : HB_RESET;
  assign host_rdata = (host_rd && host_sel_in) ? in_q : HB_RESET;

  a_r3_drive: assert property (@(posedge clk) disable iff (!rst_n)
    isa_win_wr |-> (isa_hi_oe && isa_hi_out == out_q));
  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_hi_oe |-> isa_hi_out == 8'h00);
  a_r6_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel_in) |-> host_rdata == in_q);
endmodule

// File: tb/tb_hibyte_stage.sv
module tb_hibyte_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_o = 0, sel_i = 0, wr = 0, rd = 0, wwin = 0, rwin = 0;
  logic [7:0] wdata = 0, hin = 0;
  logic [7:0] rdata, hout;
  logic oe;

  int checks = 0, fails = 0;
  logic [7:0] m_out = 0, m_in = 0, m_prev_data = 0;
  logic m_prev_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hibyte_stage dut (
    .clk(clk), .rst_n(rst_n), .host_sel_out(sel_o), .host_sel_in(sel_i),
    .host_wr(wr), .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
    .isa_win_wr(wwin), .isa_win_rd(rwin), .isa_hi_in(hin),
    .isa_hi_out(hout), .isa_hi_oe(oe)
  );

  function automatic logic [7:0] exp_rdata();
    return (rd && sel_i) ? m_in : 8'h00;
  endfunction
  function automatic logic [7:0] exp_hout();
    return wwin ? m_out : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs mid-low-phase, model updates at posedge
  task automatic step(logic so, logic si, logic w, logic r, logic [7:0] wd,
                      logic ww, logic rw, logic [7:0] hi);
    @(negedge clk);
    sel_o = so; sel_i = si; wr = w; rd = r; wdata = wd;
    wwin = ww; rwin = rw; hin = hi;
    #(CLK_PERIOD/4);
    chk("R6", rdata, exp_rdata());
    chk(ww ? "R3" : "R4", hout, exp_hout());
    chk(ww ? "R3" : "R4", {7'b0, oe}, {7'b0, ww});
    @(posedge clk);
    if (w && so) m_out = wd;
    else if (r && so) m_out = 8'h00;
    if (m_prev_rd && !rw) m_in = m_prev_data;
    m_prev_rd = rw;
    m_prev_data = hi;
  endtask

  task automatic idle(); step(0,0,0,0,8'h00,0,0,8'h00); endtask

  initial begin
    #(CLK_PERIOD*250000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state via ports
    step(0,1,0,1,8'h00,1,0,8'h00);
    chk("R1", rdata, 8'h00);
    // R2 then R3
    step(1,0,1,0,8'hA5,0,0,8'h00);
    step(0,0,0,0,8'h00,1,0,8'h00);
    chk("R2", hout, 8'hA5);
    // R7: write to inbound address has no effect
    step(0,1,1,0,8'h3C,0,0,8'h00);
    step(0,1,0,1,8'h00,1,0,8'h00);
    chk("R7", rdata, 8'h00);
    chk("R7", hout, 8'hA5);
    // R5/R9: multi-cycle read strobe with changing bus
    step(0,0,0,0,8'h00,0,1,8'h11);
    step(0,1,0,1,8'h00,0,1,8'h22);
    chk("R9", rdata, 8'h00);
    step(0,0,0,0,8'h00,0,1,8'h33);
    step(0,0,0,0,8'h00,0,0,8'h44);
    step(0,1,0,1,8'h00,0,0,8'h55);
    chk("R5", rdata, 8'h33);
    // R8: read of outbound clears, next window write drives zero
    step(1,0,0,1,8'h00,0,0,8'h00);
    step(0,0,0,0,8'h00,1,0,8'h00);
    chk("R8", hout, 8'h00);
    // R8: write wins over simultaneous read
    step(1,0,1,1,8'h7E,0,0,8'h00);
    step(0,0,0,0,8'h00,1,0,8'h00);
    chk("R8", hout, 8'h7E);
    // one-cycle read strobe
    step(0,0,0,0,8'h00,0,1,8'hC3);
    step(0,0,0,0,8'h00,0,0,8'h00);
    step(0,1,0,1,8'h00,0,0,8'h00);
    chk("R5", rdata, 8'hC3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int a;
      logic so, si;
      a = $urandom_range(0, 2);
      so = (a == 0); si = (a == 1);
      step(so, si, $urandom_range(0,3) == 0, $urandom_range(0,2) == 0,
           8'($urandom), $urandom_range(0,2) == 0, $urandom_range(0,1) == 1,
           8'($urandom));
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule